// File: doc/BRIEF.md
# Cycle-Counted Parallel Bus Host Interface

This block lets an internal controller read and write the registers of an external peripheral chip over an asynchronous parallel bus. The bus has an active-low chip select, separate active-low read and write strobes, an address bus and a data bus. The data bus is brought out as separate outgoing data, output-enable and incoming data so that a pad cell can make it bidirectional. All bus timing comes from counting whole system-clock cycles, so the external bus needs no I/O timing constraints.

The controller issues one access at a time. It raises a single-cycle request with a read/write flag, an address and, for writes, the data. The block runs a fixed sequence of phases. First comes a setup phase with chip select and address valid and both strobes high. Next comes the strobe phase. A write then adds a hold phase. The block ends every access with a one-cycle done pulse, which carries the captured word for reads. Phase lengths are parameters, and the defaults suit a 100 MHz clock: one setup cycle, two write-strobe cycles, four read-strobe cycles (40 ns, above the peripheral's 33 ns access time) and one hold cycle.

Top module: `pbus_host`

## Requirements
- R1: While reset is asserted and just after it, chip select, read strobe and write strobe are high, the data output enable is 0, and busy and done are 0.
- R2: A request accepted at a clock edge drives chip select low and puts the address on the bus at that same edge. The address stays constant while chip select is low. Chip select is low for SETUP_CYC cycles (default 1) before either strobe falls, and it is low whenever a strobe is low.
- R3: A write holds the write strobe low for WR_CYC cycles (default 2). The request's write data is on the bus with the output enable at 1 from the edge the strobe falls.
- R4: After the write strobe rises, chip select stays low and the data stays driven for HOLD_CYC more cycles (default 1). Both are then released at the same edge.
- R5: A read holds the read strobe low for RD_CYC cycles (default 4, at least 4). The data input is sampled at the edge that raises the read strobe, and chip select rises at that same edge.
- R6: The output enable is 1 only during a write access, from the write-strobe fall to the end of hold. It is never 1 while the read strobe is low. The two strobes are never low together.
- R7: done is high for exactly one cycle, the cycle right after the last bus phase. After a read, rdata shows the sampled word from that cycle on and keeps it until the next read completes. Writes leave rdata unchanged.
- R8: busy is high from the cycle after acceptance through the done cycle. A request seen while busy is high is ignored and causes no access.
- R9: Between two accesses, chip select and both strobes are high for at least one whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Single-cycle access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address for the access |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last word read |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_dout_o | output | DATA_W | Outgoing bus data |
| bus_doe_o | output | 1 | Output enable for the data pads |
| bus_din_i | input | DATA_W | Incoming bus data |

## Verification
The bench runs single writes and single reads, each followed by a long idle gap, to check each phase length on its own. A bench-side peripheral returns a poison word until the read strobe has been low for three cycles. Sampling too early therefore shows up as a wrong rdata, not as a timing window. The request line is also held high for many cycles with the operation changing every cycle, and extra request pulses are fired in the middle of accesses. These runs separate correct request acceptance and the idle gap between back-to-back accesses from requests that are wrongly taken while busy. A long series of mixed reads and writes with gaps of zero to three cycles checks that rdata survives writes and changes only when a read completes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    PB_IDLE   = 3'd0,
    PB_SETUP  = 3'd1,
    PB_STROBE = 3'd2,
    PB_HOLD   = 3'd3,
    PB_DONE   = 3'd4
  } pb_state_e;
endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)          cnt_d = load_val_i;
    else if (!zero_o)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_rcap.sv
module pbus_rcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (sample_i) rdata_q <= din_i;
  end

  assign rdata_o = rdata_q;

  // R7: captured word only moves on a sample strobe
  assert_rdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(rdata_q));
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int RD_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              doe_o
);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  pb_state_e         st_q, st_d;
  logic              cs_n_q, cs_n_d;
  logic              rd_n_q, rd_n_d;
  logic              wr_n_q, wr_n_d;
  logic              doe_q, doe_d;
  logic              wr_op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;
  logic              accept;

  assign accept = (st_q == PB_IDLE) && req_i;

  // next-state and next-output logic
  always_comb begin
    st_d       = st_q;
    cs_n_d     = cs_n_q;
    rd_n_d     = rd_n_q;
    wr_n_d     = wr_n_q;
    doe_d      = doe_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sample_o   = 1'b0;
    unique case (st_q)
      PB_IDLE: begin
        if (req_i) begin
          st_d       = PB_SETUP;
          cs_n_d     = 1'b0;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETUP_LD;
        end
      end
      PB_SETUP: begin
        if (tmr_zero_i) begin
          st_d       = PB_STROBE;
          tmr_load_o = 1'b1;
          if (wr_op_q) begin
            wr_n_d    = 1'b0;
            doe_d     = 1'b1;
            tmr_val_o = WR_LD;
          end else begin
            rd_n_d    = 1'b0;
            tmr_val_o = RD_LD;
          end
        end
      end
      PB_STROBE: begin
        if (tmr_zero_i) begin
          if (wr_op_q) begin
            st_d       = PB_HOLD;
            wr_n_d     = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = HOLD_LD;
          end else begin
            st_d     = PB_DONE;
            rd_n_d   = 1'b1;
            cs_n_d   = 1'b1;
            sample_o = 1'b1;
          end
        end
      end
      PB_HOLD: begin
        if (tmr_zero_i) begin
          st_d   = PB_DONE;
          cs_n_d = 1'b1;
          doe_d  = 1'b0;
        end
      end
      PB_DONE: st_d = PB_IDLE;
      default: st_d = PB_IDLE;
    endcase
  end

  // state and bus pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PB_IDLE;
      cs_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      doe_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
      doe_q  <= doe_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_op_q <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
    end else if (accept) begin
      wr_op_q <= req_wr_i;
      addr_q  <= req_addr_i;
      dout_q  <= req_wdata_i;
    end
  end

  assign busy_o = (st_q != PB_IDLE);
  assign done_o = (st_q == PB_DONE);
  assign cs_n_o = cs_n_q;
  assign rd_n_o = rd_n_q;
  assign wr_n_o = wr_n_q;
  assign addr_o = addr_q;
  assign dout_o = dout_q;
  assign doe_o  = doe_q;

  // consecutive read-strobe-low cycles, for the access-time check
  logic [7:0] rd_low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_low_q <= '0;
    else if (rd_n_q)            rd_low_q <= '0;
    else if (rd_low_q != 8'hFF) rd_low_q <= rd_low_q + 8'd1;
  end

  assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_q && !wr_n_q));
  assert_oe_not_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doe_q |-> rd_n_q);
  assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_q || !wr_n_q) |-> !cs_n_q);
  assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_q) || $fell(wr_n_q)) |-> !$past(cs_n_q));
  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_q) |-> (!cs_n_q && doe_q));
  assert_read_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_q) |-> (rd_low_q >= 8'd4));
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q);
endmodule

// File: rtl/pbus_host.sv
module pbus_host #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int RD_CYC    = 4,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_cs_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DATA_W-1:0] bus_din_i
);
  localparam int MAX_SW  = (SETUP_CYC > WR_CYC) ? SETUP_CYC : WR_CYC;
  localparam int MAX_RH  = (RD_CYC > HOLD_CYC) ? RD_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_SW > MAX_RH) ? MAX_SW : MAX_RH;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  logic             srst_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             sample;

  pbus_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pbus_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (srst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_i       (req_i),
    .req_wr_i    (req_wr_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sample_o    (sample),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cs_n_o      (bus_cs_n_o),
    .rd_n_o      (bus_rd_n_o),
    .wr_n_o      (bus_wr_n_o),
    .addr_o      (bus_addr_o),
    .dout_o      (bus_dout_o),
    .doe_o       (bus_doe_o)
  );

  pbus_rcap #(.DATA_W(DATA_W)) u_rcap (
    .clk      (clk),
    .rst_n    (srst_n),
    .sample_i (sample),
    .din_i    (bus_din_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: tb/tb_pbus_host.sv
module tb_pbus_host;
  localparam int AW = 8, DW = 16, S = 1, WC = 2, RC = 4, HC = 1;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_i, req_wr_i;
  logic [AW-1:0] req_addr_i;
  logic [DW-1:0] req_wdata_i;
  logic busy_o, done_o, cs_n, rd_n, wr_n, doe;
  logic [DW-1:0] rdata_o, dout, din;
  logic [AW-1:0] addr;

  pbus_host #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WR_CYC(WC),
              .RD_CYC(RC), .HOLD_CYC(HC)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_wr_i(req_wr_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .bus_cs_n_o(cs_n), .bus_rd_n_o(rd_n),
    .bus_wr_n_o(wr_n), .bus_addr_o(addr), .bus_dout_o(dout), .bus_doe_o(doe),
    .bus_din_i(din));

  int checks = 0, errors = 0;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction

  // peripheral model: poison word until the read strobe has been low 3 cycles
  int rdlow = 0;
  always @(posedge clk) rdlow <= rd_n ? 0 : rdlow + 1;
  assign din = (rdlow >= 3) ? dev_word(addr) : 16'hDEAD;

  // behavioural reference: cycle index within the current access
  int t = -1, m_end = 0;
  bit m_wr = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0, exp_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = -1; exp_rdata = '0;
    end else begin
      if (t >= 0) begin
        if (t == m_end) t = -1; else t++;
      end else if (req_i) begin
        t = 0; m_wr = req_wr_i; m_addr = req_addr_i; m_wdata = req_wdata_i;
        m_end = req_wr_i ? S + WC + HC : S + RC;
      end
      if (t == m_end && !m_wr) exp_rdata = dev_word(m_addr);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit act, e_cs, e_rd, e_wr, e_oe;
      string cs_tag;
      act  = (t >= 0);
      e_cs = act && t < m_end;
      e_rd = act && !m_wr && t >= S && t < S + RC;
      e_wr = act && m_wr && t >= S && t < S + WC;
      e_oe = act && m_wr && t >= S && t < S + WC + HC;
      cs_tag = (act && t == m_end) ? "R9" : ((act && m_wr && t >= S + WC) ? "R4" : "R2");
      chk(cs_tag, "cs_n", 32'(cs_n), 32'(!e_cs));
      chk("R5", "rd_n", 32'(rd_n), 32'(!e_rd));
      chk("R3", "wr_n", 32'(wr_n), 32'(!e_wr));
      chk((act && m_wr && t >= S + WC) ? "R4" : "R6", "doe", 32'(doe), 32'(e_oe));
      chk("R8", "busy", 32'(busy_o), 32'(act));
      chk("R7", "done", 32'(done_o), 32'(act && t == m_end));
      if (e_cs) chk("R2", "addr", 32'(addr), 32'(m_addr));
      if (e_oe) chk("R3", "wdata", 32'(dout), 32'(m_wdata));
      chk((act && t == m_end && !m_wr) ? "R5" : "R7", "rdata", 32'(rdata_o), 32'(exp_rdata));
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_i = 1'b1; req_wr_i = wr; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; req_wr_i = 1'b0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk("R1", "cs_n", 32'(cs_n), 32'd1);
    chk("R1", "rd_n", 32'(rd_n), 32'd1);
    chk("R1", "wr_n", 32'(wr_n), 32'd1);
    chk("R1", "doe",  32'(doe),  32'd0);
    chk("R1", "busy", 32'(busy_o), 32'd0);
    chk("R1", "done", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "rdata after reset", 32'(rdata_o), 32'd0);

    // single write, then single read, long gaps
    do_req(1'b1, 8'hA0, 16'h1234);
    repeat (10) @(negedge clk);
    do_req(1'b0, 8'h3C, 16'hFFFF);
    repeat (10) @(negedge clk);

    // R8/R9: request held high, operation flipping every cycle
    req_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      req_wr_i = i[0]; req_addr_i = 8'(i * 11 + 3); req_wdata_i = 16'(i * 513 + 9);
      @(negedge clk);
    end
    req_i = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);

    // R8: extra pulses in the middle of accesses are ignored
    do_req(1'b0, 8'h55, 16'h0);
    @(negedge clk);
    do_req(1'b1, 8'hEE, 16'hBEEF);
    do_req(1'b0, 8'h11, 16'h0);
    wait_idle();
    do_req(1'b1, 8'h22, 16'hCAFE);
    repeat (2) @(negedge clk);
    do_req(1'b0, 8'h77, 16'h0);
    wait_idle();

    // R7: mixed series with varying gaps
    for (int i = 0; i < 40; i++) begin
      do_req(i % 3 == 0, 8'(i * 37 + 5), 16'(i * 4099 + 7));
      wait_idle();
      repeat (i % 4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule